// File: doc/BRIEF.md
# Seven-to-One Parallel Link Serializer

This block turns a wide parallel pixel word into a few narrow serial lanes for a flat-panel cable. Once per pixel-clock period it captures a 28-bit word and sends it as four data lanes. Each lane carries seven bit slots per word, so every lane runs at seven times the pixel rate; an 85 MHz pixel clock gives 595 Mb/s per lane. A fifth lane carries a forwarded clock that repeats a fixed seven-slot pattern once per word, so the far end can find the word boundaries.

The block runs entirely on an externally supplied bit clock at seven times the pixel rate. The pixel clock arrives as an ordinary input that the bit clock samples. One mode input selects a narrow 21-bit, three-lane format. Another selects whether words are taken on the rising or the falling pixel-clock transition. An active-low sleep input turns off every output enable. After waking, the outputs stay off until a programmable number of pixel periods has passed. Output enables stand in for high-impedance pads.

Top module: `sl7_serializer`

## Requirements
- R1: For every selected pixel-clock transition the block captures one word, and each enabled data lane sends seven bit slots for it, one slot per bit-clock cycle.
- R2: While a word was captured with `narrow` high, only bits 0..20 are sent, on lanes 0..2. Lane 3 has its enable low and its data output low, and input bits 21..27 have no effect on any output.
- R3: Slot s of a word (s = 0 is sent first) on lane l carries input bit (6 - s) * N + l, where N is 4 in full mode and 3 in narrow mode.
- R4: With `edge_rise` high a word is captured on the rising pixel-clock transition, and with it low on the falling one. Slot 0 of that word appears after the second bit-clock edge that follows the edge at which the bit clock first samples the new pixel-clock level. Slot s appears s cycles later.
- R5: One bit-clock edge after `sleep_n` is seen low, every data enable and the clock-lane enable are low, and every data output and `clk_out` read 0. This holds whatever the other inputs do.
- R6: After `sleep_n` returns high, the enables stay low until SETTLE_WORDS selected pixel transitions have been captured. They then rise together at the first slot 0 of the next word.
- R7: While enabled, the clock lane sends 1,1,0,0,0,1,1 over slots 0..6. Its falling transition therefore lands two slot times after the first, most significant slot of each data word.
- R8: The full or narrow format is sampled together with each word and applies to that word alone, so the format can change from one word to the next without losing or corrupting a word.
- R9: After reset, all enables and all serial outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled by `clk` |
| edge_rise | input | 1 | 1: capture on rising pixel transition, 0: on falling |
| narrow | input | 1 | 1: 21-bit three-lane format, 0: 28-bit four-lane format |
| sleep_n | input | 1 | Active-low power-down |
| din | input | 28 | Parallel pixel word |
| ser_data | output | 4 | Serial data lanes |
| ser_en | output | 4 | Per-lane output enable (low = high impedance) |
| clk_out | output | 1 | Forwarded clock lane |
| clk_en | output | 1 | Forwarded clock lane enable |

## Verification
Every combination of capture edge and lane format is driven with four word patterns. Walking ones and walking zeros single out each input bit, so a lane or slot swap in the bit mapping shows up as a mismatch at one exact position. All-ones and all-zeros alternating words catch stuck or missing slots. Pseudo-random words exercise mixed transitions. A run that switches format on every third word separates the per-word format latch from a global one, and sleep pulses in the middle of a run check the immediate shutdown and the exact count of settle periods before the outputs come back.

// File: rtl/sl7_pkg.sv
`timescale 1ns/1ps
package sl7_pkg;
  // Bit slots per lane per pixel word (the 7:1 ratio is the block's nature).
  localparam int SLOTS  = 7;
  localparam int SLOT_W = $clog2(SLOTS);

  // Forwarded clock pattern, bit SLOTS-1 is sent first.
  localparam logic [SLOTS-1:0] FWD_CLK_PAT = 7'b1100011;

  // Input bit carried by lane `lane` in slot `slot` (0 = first sent)
  // when `nlanes` lanes are active.
  function automatic int src_bit(input int lane, input int slot, input int nlanes);
    return (SLOTS - 1 - slot) * nlanes + lane;
  endfunction

  // Slot counter advance with wrap.
  function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(SLOTS - 1)) ? '0 : s + 1'b1;
  endfunction
endpackage

// File: rtl/sl7_capture.sv
`timescale 1ns/1ps
module sl7_capture
  import sl7_pkg::*;
#(
  parameter int DW = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_clk,
  input  logic              edge_rise,
  input  logic              narrow,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     hold_word,
  output logic              hold_narrow,
  output logic              cap_evt,
  output logic              load_evt
);
  logic              pix_q, pix_qq;
  logic [SLOT_W-1:0] slot_q;

  // Sample the pixel clock in the bit-clock domain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= 1'b0;
      pix_qq <= 1'b0;
    end else begin
      pix_q  <= pix_clk;
      pix_qq <= pix_q;
    end
  end

  // Selected pixel transition seen this cycle.
  assign cap_evt = (pix_q ^ pix_qq) & (pix_q == edge_rise);

  // Holding register, written once per pixel period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word   <= '0;
      hold_narrow <= 1'b0;
    end else if (cap_evt) begin
      hold_word   <= din;
      hold_narrow <= narrow;
    end
  end

  // Slot counter, realigned by every capture so latency stays constant.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot_q <= SLOT_W'(1);
    else if (cap_evt) slot_q <= '0;
    else              slot_q <= slot_next(slot_q);
  end

  assign load_evt = (slot_q == '0);

  // R1: a word frame lasts more than one slot.
  assert_single_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !load_evt);
endmodule

// File: rtl/sl7_lane.sv
`timescale 1ns/1ps
module sl7_lane #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] par,
  output logic         bit_out
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (load) sh_q <= par;
    else           sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign bit_out = sh_q[W-1];
endmodule

// File: rtl/sl7_gate.sv
`timescale 1ns/1ps
module sl7_gate #(
  parameter int SETTLE_WORDS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  input  logic cap_evt,
  input  logic load_evt,
  input  logic hold_narrow,
  output logic out_en,
  output logic word_narrow
);
  localparam int CNT_W = $clog2(SETTLE_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_WORDS);

  logic [CNT_W-1:0] settle_cnt;
  logic             settled;

  assign settled = (settle_cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  settle_cnt <= '0;
    else if (!sleep_n)           settle_cnt <= '0;
    else if (cap_evt && !settled) settle_cnt <= settle_cnt + 1'b1;
  end

  // Enables change only at a word start, except shutdown which is immediate.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_en <= 1'b0;
    else if (!sleep_n) out_en <= 1'b0;
    else if (load_evt) out_en <= settled;
  end

  // Format follows the word into the lanes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_narrow <= 1'b0;
    else if (load_evt) word_narrow <= hold_narrow;
  end

  assert_sleep_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !out_en);

  assert_settle_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> (settle_cnt == CNT_MAX));

  assert_enable_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> $past(load_evt));
endmodule

// File: rtl/sl7_serializer.sv
`timescale 1ns/1ps
module sl7_serializer
  import sl7_pkg::*;
#(
  parameter int LANES        = 4,
  parameter int RED_LANES    = 3,
  parameter int SETTLE_WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pix_clk,
  input  logic                     edge_rise,
  input  logic                     narrow,
  input  logic                     sleep_n,
  input  logic [LANES*SLOTS-1:0]   din,
  output logic [LANES-1:0]         ser_data,
  output logic [LANES-1:0]         ser_en,
  output logic                     clk_out,
  output logic                     clk_en
);
  localparam int DW = LANES * SLOTS;

  logic [DW-1:0]    hold_word;
  logic             hold_narrow;
  logic             cap_evt;
  logic             load_evt;
  logic             out_en;
  logic             word_narrow;
  logic [LANES-1:0] lane_bit;
  logic             clk_raw;

  sl7_capture #(.DW(DW)) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_clk     (pix_clk),
    .edge_rise   (edge_rise),
    .narrow      (narrow),
    .din         (din),
    .hold_word   (hold_word),
    .hold_narrow (hold_narrow),
    .cap_evt     (cap_evt),
    .load_evt    (load_evt)
  );

  sl7_gate #(.SETTLE_WORDS(SETTLE_WORDS)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_n     (sleep_n),
    .cap_evt     (cap_evt),
    .load_evt    (load_evt),
    .hold_narrow (hold_narrow),
    .out_en      (out_en),
    .word_narrow (word_narrow)
  );

  // Data lanes: mapping picked per lane and slot at elaboration.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] par;
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int IDX_FULL = src_bit(l, s, LANES);
      localparam int IDX_NAR  = (l < RED_LANES) ? src_bit(l, s, RED_LANES) : 0;
      if (l < RED_LANES) begin : g_shared
        assign par[SLOTS-1-s] = hold_narrow ? hold_word[IDX_NAR] : hold_word[IDX_FULL];
      end else begin : g_full_only
        assign par[SLOTS-1-s] = hold_narrow ? 1'b0 : hold_word[IDX_FULL];
      end
    end

    sl7_lane #(.W(SLOTS)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_evt),
      .par     (par),
      .bit_out (lane_bit[l])
    );

    if (l < RED_LANES) begin : g_en_shared
      assign ser_en[l] = out_en;
    end else begin : g_en_full_only
      assign ser_en[l] = out_en & ~word_narrow;
    end
    assign ser_data[l] = ser_en[l] & lane_bit[l];
  end

  // Forwarded clock lane.
  sl7_lane #(.W(SLOTS)) u_fwd_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_evt),
    .par     (FWD_CLK_PAT),
    .bit_out (clk_raw)
  );

  assign clk_en  = out_en;
  assign clk_out = out_en & clk_raw;

  // R7: first clock slot after a load is high.
  assert_fwd_clk_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> clk_raw);

  // R7: the forwarded clock falls two slots after the word's first slot.
  assert_fwd_clk_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_raw) |-> $past(load_evt, 3));
endmodule

// File: tb/test_sl7_serializer.sv
`timescale 1ns/1ps
module test_sl7_serializer;
  localparam int LN = 4;
  localparam int RL = 3;
  localparam int SW = 3;
  localparam int DW = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_clk = 1'b0;
  logic          edge_rise = 1'b1;
  logic          narrow = 1'b0;
  logic          sleep_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [LN-1:0] ser_data, ser_en;
  logic          clk_out, clk_en;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  int t = 0;              // index of the next bit-clock posedge
  int caps = 0;           // captures seen since wake (model)
  bit exp_en = 1'b0;      // expected enable state (model)
  int k = 0;              // word counter
  logic [31:0] lcg = 32'h1234_5678;
  logic [DW-1:0] hd [16];
  bit            hm [16];

  always #2.5 clk = ~clk;

  sl7_serializer #(.LANES(LN), .RED_LANES(RL), .SETTLE_WORDS(SW)) i_sl7_serializer (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_clk   (pix_clk),
    .edge_rise (edge_rise),
    .narrow    (narrow),
    .sleep_n   (sleep_n),
    .din       (din),
    .ser_data  (ser_data),
    .ser_en    (ser_en),
    .clk_out   (clk_out),
    .clk_en    (clk_en)
  );

  function automatic logic [DW-1:0] word_of(input int pat, input int n, input logic [31:0] rnd);
    logic [DW-1:0] one = DW'(1) << (n % DW);
    case (pat)
      0:       return one;                        // walking one
      1:       return ~one;                       // walking zero
      2:       return rnd[DW-1:0];                // pseudo-random
      default: return (n % 2) ? '1 : '0;          // all ones / all zeros
    endcase
  endfunction

  // Compare all outputs after posedge t, phase ph.
  task automatic check_outputs(input int ph);
    int ps = edge_rise ? 2 : 6;
    int s = (ph - ps + 7) % 7;
    int src = t - s - 1;
    logic [DW-1:0] w;
    bit m;
    logic [LN-1:0] een, edat;
    logic ece, eco;
    string tag;
    w = (src >= 0) ? hd[src % 16] : '0;
    m = (src >= 0) ? hm[src % 16] : 1'b0;
    for (int l = 0; l < LN; l++) begin
      een[l]  = exp_en && (!m || l < RL);
      edat[l] = een[l] ? w[(6 - s) * (m ? RL : LN) + l] : 1'b0;   // R3 mapping
    end
    ece = exp_en;
    eco = exp_en && (s < 2 || s > 4);                             // R7 pattern
    vectors++;
    if ({ser_en, ser_data, clk_en, clk_out} !== {een, edat, ece, eco}) begin
      miscompares++;
      if (!exp_en)               tag = sleep_n ? "R6" : "R5";
      else if (ser_en !== een)   tag = "R2/R8";
      else if (ser_data !== edat) tag = m ? "R2/R8" : (edge_rise ? "R1/R3" : "R4");
      else                       tag = "R7";
      $display("FAIL %s t=%0d slot=%0d actual en=%b data=%b clk=%b%b expected en=%b data=%b clk=%b%b",
               tag, t, s, ser_en, ser_data, clk_en, clk_out, een, edat, ece, eco);
    end
  endtask

  // One bit-clock cycle: drive, model the posedge, check at the negedge.
  task automatic step(input int pat, input bit mix);
    int ph = t % 7;
    int ps = edge_rise ? 2 : 6;
    int cp = edge_rise ? 1 : 5;
    int dch = edge_rise ? 4 : 0;
    pix_clk = (ph < 4);
    if (ph == dch) begin
      k++;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      din = word_of(pat, k, lcg);
      if (mix) narrow = (k % 3 == 0);                            // R8
    end
    hd[t % 16] = din;
    hm[t % 16] = narrow;
    @(posedge clk);
    if (!sleep_n) begin
      caps = 0;
      exp_en = 1'b0;
    end else begin
      if (ph == ps) exp_en = (caps >= SW);                       // R6
      if (ph == cp && caps < SW) caps++;                         // R4 capture edge
    end
    @(negedge clk);
    check_outputs(ph);
    t++;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    vectors++;
    if ({ser_en, ser_data, clk_en, clk_out} !== '0) begin
      miscompares++;
      $display("FAIL R9 reset actual=%b expected=0", {ser_en, ser_data, clk_en, clk_out});
    end
    rst_n = 1'b1;

    // R1..R7 over both capture edges and both formats.
    for (int e = 1; e >= 0; e--) begin
      for (int mo = 0; mo < 2; mo++) begin
        sleep_n = 1'b0;
        edge_rise = e[0];
        narrow = mo[0];
        repeat (14) step(2, 1'b0);                               // R5 while asleep
        sleep_n = 1'b1;
        for (int p = 0; p < 4; p++) repeat (7 * 30) step(p, 1'b0);
      end
    end

    // R8: format changes word by word.
    repeat (7 * 40) step(2, 1'b1);
    repeat (7 * 30) step(0, 1'b1);

    // R5/R6: sleep pulse in mid-run, then wake and settle again.
    sleep_n = 1'b0;
    repeat (9) step(3, 1'b0);
    sleep_n = 1'b1;
    repeat (7 * 12) step(2, 1'b0);
    sleep_n = 1'b0;
    repeat (2) step(2, 1'b0);
    sleep_n = 1'b1;
    repeat (7 * 12) step(0, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule